// File: doc/BRIEF.md
# SDRAM Row/Column Address Sequencer

This block turns a linear byte address into the two address phases that a 16-pin SDRAM address bus needs. It also works out how many column beats the access takes and steps the column word address through them. Three kinds of requester share it: a processor, a display controller and a multi-channel DMA engine. The kind of requester, the DMA channel's addressing mode and the transfer target decide the burst length. A per-channel length field, programmed elsewhere, sets the DMA burst when it applies.

A request is taken when `req_valid` is high while `req_ready` is high. The next cycle presents the row address for exactly one cycle. The column beats follow with no gap, and the last beat raises `burst_done`. A two-bit width setting moves the row split point and sets how many column bits are valid. Pin 10 carries the auto-precharge flag during column beats. Command timing, refresh, banks and data are handled by the surrounding controller.

Top module: `sdram_addr_seq`

## Requirements
- R1: With `width_sel` = 00, the row phase drives pins 15..0 with byte-address bits 24..9, and the page has 8 column bits.
- R2: With `width_sel` = 01, the row phase drives byte-address bits 25..10, and the page has 9 column bits.
- R3: With `width_sel` = 10, the row phase drives byte-address bits 26..11, and the page has 10 column bits.
- R4: `width_sel` = 11 is reserved. It maps the address exactly like 10, and `cfg_err` is high while it is applied.
- R5: In a column beat, pins 9..0 carry the column word address. The first beat takes byte-address bits 10..1, with bits at or above the page's column-bit count forced low. Pins 15..11 are low.
- R6: In every column beat, pin 10 carries the `auto_pre` value captured when the request was taken.
- R7: A request with `req_src` = 00 (processor) or the reserved value 11 runs a single beat.
- R8: A request with `req_src` = 01 (display) runs a full page of 2^(column bits) beats.
- R9: A request with `req_src` = 10 (DMA) runs F+1 beats when both `dma_incr` and `to_internal` are high. F is the 6-bit field at bits [6c+5:6c] of `dma_len_flat` for channel c = `dma_chan`. Otherwise it runs one beat.
- R10: Each beat after the first raises the column word address by one, wrapping to zero within the page.
- R11: The row phase lasts exactly one cycle, in the cycle after acceptance. Column beats follow it at once, and `burst_done` is high on the final beat only. `req_ready` returns in the cycle after `burst_done`.
- R12: `req_ready` is low from acceptance until the end of the burst. Changes on the request inputs during that time do not alter the running burst's pins or length.
- R13: After reset, `req_ready` is high, both phase outputs and `burst_done` are low, and the pins are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 27 | Linear byte address |
| req_src | input | 2 | Requester: 00 processor, 01 display, 10 DMA, 11 reserved |
| dma_chan | input | 2 | DMA channel number |
| dma_incr | input | 1 | DMA channel uses address-increment mode |
| to_internal | input | 1 | Transfer partner is internal RAM or internal I/O |
| auto_pre | input | 1 | Auto-precharge flag for the column beats |
| width_sel | input | 2 | Multiplex width setting |
| dma_len_flat | input | 24 | Per-channel burst-length fields, 6 bits each |
| req_ready | output | 1 | Idle, a request may be taken |
| addr_pins | output | 16 | SDRAM address bus |
| phase_row | output | 1 | Pins carry the row address |
| phase_col | output | 1 | Pins carry a column beat |
| burst_done | output | 1 | Final column beat |
| cfg_err | output | 1 | Reserved width setting applied |

## Verification
The row address is due one cycle after the edge that takes the request. Column beat k is due k+2 cycles after that edge, and `req_ready` returns one cycle after the final beat. The bench drives inputs and samples outputs on falling edges. From the acceptance edge it counts falling edges, so each check lands in the cycle its result is due: the row, every beat's column and done flag, then the ready flag. `cfg_err` is combinational on `width_sel` and is checked in the same cycle the setting is driven.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [1:0] {
        SRC_CPU  = 2'b00,
        SRC_DISP = 2'b01,
        SRC_DMA  = 2'b10,
        SRC_RSVD = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ROW  = 2'b01,
        ST_COL  = 2'b10
    } seq_st_e;

endpackage

// File: rtl/sdram_rc_map.sv
module sdram_rc_map #(
    parameter int ADDR_W   = 27,
    parameter int PIN_W    = 16,
    parameter int ROW_BASE = 9,
    parameter int COL_MIN  = 8,
    localparam int COLW    = COL_MIN + 2
) (
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [1:0]        width_sel,
    output logic [PIN_W-1:0]  row_addr,
    output logic [COLW-1:0]   col_start,
    output logic [COLW-1:0]   col_mask,
    output logic [COLW:0]     page_beats,
    output logic              width_bad
);
    localparam logic [COLW:0]   ONE_P = 1;
    localparam logic [COLW-1:0] ONE_C = 1;

    logic [1:0]       step;
    logic [PIN_W-1:0] cand [3];

    for (genvar g = 0; g < 3; g++) begin : g_row
        assign cand[g] = byte_addr[ROW_BASE+g +: PIN_W];
    end

    always_comb begin
        width_bad  = (width_sel == 2'b11);
        step       = width_bad ? 2'b10 : width_sel;
        row_addr   = cand[step];
        page_beats = ONE_P << (COL_MIN + 32'(step));
        col_mask   = page_beats[COLW-1:0] - ONE_C;
        col_start  = byte_addr[COLW:1] & col_mask;
    end

endmodule

// File: rtl/sdram_burst_sel.sv
module sdram_burst_sel
    import sdram_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int BL_W   = 6,
    parameter int CNT_W  = 11,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [1:0]           src,
    input  logic [CH_W-1:0]      chan,
    input  logic                 incr,
    input  logic                 internal,
    input  logic [NUM_CH*BL_W-1:0] len_flat,
    input  logic [CNT_W-1:0]     page_beats,
    output logic [CNT_W-1:0]     beats
);
    localparam logic [CNT_W-1:0] ONE_B = 1;

    logic [BL_W-1:0]  fld [NUM_CH];
    logic [CNT_W-1:0] dma_beats;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_fld
        assign fld[g] = len_flat[g*BL_W +: BL_W];
    end

    always_comb begin
        dma_beats = ONE_B;
        if (incr && internal)
            dma_beats = {{(CNT_W-BL_W){1'b0}}, fld[chan]} + ONE_B;
        case (src_e'(src))
            SRC_DISP: beats = page_beats;
            SRC_DMA:  beats = dma_beats;
            default:  beats = ONE_B;
        endcase
    end

endmodule

// File: rtl/sdram_addr_seq.sv
module sdram_addr_seq
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W   = 27,
    parameter int PIN_W    = 16,
    parameter int ROW_BASE = 9,
    parameter int COL_MIN  = 8,
    parameter int NUM_CH   = 4,
    parameter int BL_W     = 6,
    localparam int COLW    = COL_MIN + 2,
    localparam int CNT_W   = COLW + 1,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [1:0]             req_src,
    input  logic [CH_W-1:0]        dma_chan,
    input  logic                   dma_incr,
    input  logic                   to_internal,
    input  logic                   auto_pre,
    input  logic [1:0]             width_sel,
    input  logic [NUM_CH*BL_W-1:0] dma_len_flat,
    output logic                   req_ready,
    output logic [PIN_W-1:0]       addr_pins,
    output logic                   phase_row,
    output logic                   phase_col,
    output logic                   burst_done,
    output logic                   cfg_err
);
    localparam logic [COLW-1:0]  ONE_C = 1;
    localparam logic [CNT_W-1:0] ONE_B = 1;

    typedef struct packed {
        seq_st_e          st;
        logic [PIN_W-1:0] row;
        logic [COLW-1:0]  col;
        logic [COLW-1:0]  mask;
        logic [CNT_W-1:0] left;
        logic             ap;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [PIN_W-1:0] map_row;
    logic [COLW-1:0]  map_col;
    logic [COLW-1:0]  map_mask;
    logic [CNT_W-1:0] map_page;
    logic [CNT_W-1:0] sel_beats;

    sdram_rc_map #(
        .ADDR_W  (ADDR_W),
        .PIN_W   (PIN_W),
        .ROW_BASE(ROW_BASE),
        .COL_MIN (COL_MIN)
    ) u_map (
        .byte_addr (req_addr),
        .width_sel (width_sel),
        .row_addr  (map_row),
        .col_start (map_col),
        .col_mask  (map_mask),
        .page_beats(map_page),
        .width_bad (cfg_err)
    );

    sdram_burst_sel #(
        .NUM_CH(NUM_CH),
        .BL_W  (BL_W),
        .CNT_W (CNT_W)
    ) u_len (
        .src       (req_src),
        .chan      (dma_chan),
        .incr      (dma_incr),
        .internal  (to_internal),
        .len_flat  (dma_len_flat),
        .page_beats(map_page),
        .beats     (sel_beats)
    );

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st   = ST_ROW;
                    seq_d.row  = map_row;
                    seq_d.col  = map_col;
                    seq_d.mask = map_mask;
                    seq_d.left = sel_beats - ONE_B;
                    seq_d.ap   = auto_pre;
                end
            end
            ST_ROW: seq_d.st = ST_COL;
            ST_COL: begin
                if (seq_q.left == '0) begin
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.left = seq_q.left - ONE_B;
                    seq_d.col  = (seq_q.col + ONE_C) & seq_q.mask;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        req_ready  = (seq_q.st == ST_IDLE);
        phase_row  = (seq_q.st == ST_ROW);
        phase_col  = (seq_q.st == ST_COL);
        burst_done = phase_col && (seq_q.left == '0);
        addr_pins  = '0;
        if (phase_row) addr_pins = seq_q.row;
        if (phase_col) addr_pins = {{(PIN_W-COLW-1){1'b0}}, seq_q.ap, seq_q.col};
    end

endmodule

// File: rtl/sdram_addr_seq_chk.sv
module sdram_addr_seq_chk #(
    parameter int PIN_W = 16,
    parameter int COLW  = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [PIN_W-1:0] addr_pins,
    input logic             phase_row,
    input logic             phase_col,
    input logic             burst_done
);
    localparam logic [COLW-1:0] ONE_C = 1;

    AST_ACCEPT_TO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> phase_row); // R11
    AST_ROW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_row |=> phase_col && !phase_row); // R11
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_row && phase_col)); // R11
    AST_DONE_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> req_ready && !phase_col); // R11
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_row || phase_col) |-> !req_ready); // R12
    AST_COL_HIGH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        phase_col |-> addr_pins[PIN_W-1:COLW+1] == '0); // R5
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        phase_col && !burst_done |=> phase_col &&
        (addr_pins[COLW-1:0] == $past(addr_pins[COLW-1:0]) + ONE_C ||
         addr_pins[COLW-1:0] == '0)); // R10
    AST_AP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        phase_col && $past(phase_col) |-> $stable(addr_pins[COLW])); // R6

endmodule

bind sdram_addr_seq sdram_addr_seq_chk #(.PIN_W(PIN_W), .COLW(COLW)) u_chk (.*);

// File: tb/tb_sdram_addr_seq.sv
module tb_sdram_addr_seq;

    typedef struct packed {
        logic [26:0] addr;
        logic [1:0]  src;
        logic [1:0]  ch;
        logic        inc;
        logic        intl;
        logic        ap;
        logic [1:0]  wsel;
        logic [11:0] beats;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{27'h1234567, 2'b00, 2'd0, 1'b0, 1'b0, 1'b1, 2'b00, 12'd1},    // R7 R1
        '{27'h2ABCDEF, 2'b01, 2'd0, 1'b0, 1'b0, 1'b0, 2'b01, 12'd512},  // R8 R2
        '{27'h7FFFFFF, 2'b10, 2'd0, 1'b1, 1'b1, 1'b1, 2'b10, 12'd4},    // R9 R3 R10
        '{27'h00007FC, 2'b10, 2'd2, 1'b1, 1'b1, 1'b0, 2'b10, 12'd8},    // R9 R10
        '{27'h0F0F0F0, 2'b10, 2'd0, 1'b0, 1'b1, 1'b0, 2'b00, 12'd1},    // R9 no incr
        '{27'h5555555, 2'b10, 2'd2, 1'b1, 1'b0, 1'b1, 2'b01, 12'd1},    // R9 external
        '{27'h4321ABC, 2'b00, 2'd0, 1'b0, 1'b0, 1'b1, 2'b11, 12'd1},    // R4
        '{27'h00001FE, 2'b01, 2'd0, 1'b0, 1'b0, 1'b1, 2'b00, 12'd256},  // R8 R10
        '{27'h3000000, 2'b01, 2'd0, 1'b0, 1'b0, 1'b0, 2'b10, 12'd1024}, // R8
        '{27'h1000002, 2'b10, 2'd3, 1'b1, 1'b1, 1'b0, 2'b01, 12'd1},    // R9 zero field
        '{27'h0ABCDE0, 2'b11, 2'd1, 1'b1, 1'b1, 1'b1, 2'b00, 12'd1},    // R7 reserved src
        '{27'h6EDCBA8, 2'b10, 2'd1, 1'b1, 1'b1, 1'b1, 2'b11, 12'd64}    // R9 max field, R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [26:0] req_addr = '0;
    logic [1:0]  req_src = '0;
    logic [1:0]  dma_chan = '0;
    logic        dma_incr = 1'b0;
    logic        to_internal = 1'b0;
    logic        auto_pre = 1'b0;
    logic [1:0]  width_sel = '0;
    logic [23:0] dma_len_flat = {6'd0, 6'd7, 6'd63, 6'd3};
    logic        req_ready;
    logic [15:0] addr_pins;
    logic        phase_row, phase_col, burst_done, cfg_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    sdram_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_src(req_src), .dma_chan(dma_chan), .dma_incr(dma_incr),
        .to_internal(to_internal), .auto_pre(auto_pre), .width_sel(width_sel),
        .dma_len_flat(dma_len_flat), .req_ready(req_ready), .addr_pins(addr_pins),
        .phase_row(phase_row), .phase_col(phase_col), .burst_done(burst_done),
        .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int width_step(input logic [1:0] w);
        return (w == 2'b11) ? 2 : int'(w);
    endfunction

    function automatic string row_req(input logic [1:0] w);
        case (w)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic run_vec(input vec_t v, input bit keep_req);
        int s = width_step(v.wsel);
        logic [15:0] exp_row = 16'((v.addr >> (9 + s)) & 27'hFFFF);
        logic [9:0]  mask = 10'((1 << (8 + s)) - 1);
        logic [9:0]  col0 = 10'(v.addr >> 1) & mask;
        logic [9:0]  exp_col;
        @(negedge clk);
        req_addr = v.addr; req_src = v.src; dma_chan = v.ch; dma_incr = v.inc;
        to_internal = v.intl; auto_pre = v.ap; width_sel = v.wsel; req_valid = 1'b1;
        #1;
        check(req_ready, "R12", 32'(req_ready), 1);
        check(cfg_err == (v.wsel == 2'b11), "R4", 32'(cfg_err), 32'(v.wsel == 2'b11));
        @(negedge clk);
        if (keep_req) begin
            req_addr = ~v.addr; req_src = 2'b00; auto_pre = ~v.ap; width_sel = 2'b00;
            dma_chan = 2'd1;
        end else begin
            req_valid = 1'b0;
        end
        check(phase_row && !phase_col, "R11", {phase_row, phase_col}, 32'h2);
        check(addr_pins == exp_row, row_req(v.wsel), 32'(addr_pins), 32'(exp_row));
        for (int i = 0; i < int'(v.beats); i++) begin
            @(negedge clk);
            exp_col = 10'(32'(col0) + i) & mask;
            check(phase_col, "R11", 32'(phase_col), 1);
            check(addr_pins[9:0] == exp_col, (i == 0) ? "R5" : "R10",
                  32'(addr_pins[9:0]), 32'(exp_col));
            check(addr_pins[10] == v.ap, "R6", 32'(addr_pins[10]), 32'(v.ap));
            check(addr_pins[15:11] == 5'd0, "R5", 32'(addr_pins[15:11]), 0);
            check(burst_done == (i == int'(v.beats) - 1),
                  (v.src == 2'b01) ? "R8" : (v.src == 2'b10) ? "R9" : "R7",
                  32'(burst_done), 32'(i == int'(v.beats) - 1));
            if (keep_req) check(!req_ready, "R12", 32'(req_ready), 0);
        end
        req_valid = 1'b0;
        @(negedge clk);
        check(req_ready && !phase_col, "R11", {req_ready, phase_col}, 32'h2);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: run did not finish");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check(req_ready == 1'b1, "R13", 32'(req_ready), 1);
        check(!phase_row && !phase_col && !burst_done, "R13",
              {phase_row, phase_col, burst_done}, 0);
        check(addr_pins == 16'h0, "R13", 32'(addr_pins), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !phase_row, "R13", {req_ready, phase_row}, 32'h2);

        for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0);

        // R12: inputs changed during a burst leave it untouched
        run_vec('{27'h00007FC, 2'b10, 2'd2, 1'b1, 1'b1, 1'b1, 2'b10, 12'd8}, 1'b1);
        // R4: cfg_err clears on a legal setting
        @(negedge clk);
        width_sel = 2'b10;
        #1;
        check(cfg_err == 1'b0, "R4", 32'(cfg_err), 0);
        width_sel = 2'b11;
        #1;
        check(cfg_err == 1'b1, "R4", 32'(cfg_err), 1);
        // R11: idle bus stays quiet without a request
        repeat (2) @(negedge clk);
        check(!phase_row && !phase_col && addr_pins == 16'h0, "R11",
              {phase_row, phase_col}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule